// File: doc/BRIEF.md
# Serial Character Receiver with Idle-Line Mute

This block turns an asynchronous serial line into 8-bit characters. A frame is one low start bit, eight data bits sent least significant first and one high stop bit. The line is sampled on an oversampling tick that runs at sixteen times the bit rate, and each bit is taken at its middle. Each finished character lands in a read-side holding register of its own, which has no connection to any transmit path. A receive-full flag tells software that a character is waiting. An overrun flag records a character that arrived while the previous one was still unread.

Software drives two controls. The first is an enable input. The second is a mute bit, written through a write strobe and a data bit. While the mute bit is set, the frame engine keeps decoding characters, but none of them reaches the holding register or the flags. The receiver leaves mute by itself when it sees one full character time of idle line. At 16 ticks per bit and 10 bits per character, that is 160 consecutive high samples, and it clears the mute bit when it happens. This wake-up is armed only once at least one correctly framed character has been received since reset. Before that, an idle line never clears mute.

The frame engine has four named states. HUNT waits for a low sample. START checks the middle of the start bit. DATA collects the data bits. STOP checks the stop bit. Its transitions are:

- HUNT to START on a low sample.
- START back to HUNT on a false start, when the line is high at the middle of the start bit.
- START to DATA when the start bit is confirmed low.
- DATA to STOP after the last data bit.
- STOP to HUNT at the middle of the stop bit.
- Any state to HUNT when the enable input is low.

Top module: `urx_mute_rx`

## Requirements
- R1: With `rx_en` low the frame engine stays in HUNT and a frame on `rxd` neither sets `rx_full` nor changes `rx_data`.
- R2: A frame of one low start bit, 8 data bits LSB first and a high stop bit, sampled at mid-bit with 16 `os_tick` pulses per bit, is written to `rx_data` and sets `rx_full` when not muted.
- R3: If the line is high again at the middle of the start bit (the 8th tick after the falling edge), the engine returns to HUNT without producing a character, and the next frame is received normally.
- R4: A frame whose stop bit is sampled low is discarded: `rx_full` and `rx_data` keep their values.
- R5: A one-cycle `rd_stb` pulse clears `rx_full` and `rx_overrun`.
- R6: A character completing while `rx_full` is 1 and no read is in progress sets `rx_overrun` and leaves `rx_data` holding the older character.
- R7: A cycle with `mute_wr` high loads `mute_wval` into `mute` (1 = muted, 0 = active); a software write takes priority over a hardware clear in the same cycle.
- R8: While `mute` is 1, completed characters update neither `rx_data` nor `rx_full`; once `mute` is 0 again, characters are delivered.
- R9: While muted and armed, 160 consecutive high samples of the line (10 bit times) clear `mute`; writing `mute` to 1 restarts this count, so a wake-up always needs a full idle character after the write.
- R10: Until a correctly framed character has been received since reset (whether muted or not), an idle line never clears `mute`.
- R11: After reset, `rx_full`, `rx_overrun` and `mute` are 0; `rx_data` has no defined reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receiver enable |
| mute_wr | input | 1 | Write strobe for the mute bit |
| mute_wval | input | 1 | Value written to the mute bit |
| rd_stb | input | 1 | Read strobe for the holding register |
| rx_data | output | 8 | Received character holding register |
| rx_full | output | 1 | A character is waiting to be read |
| rx_overrun | output | 1 | A character arrived while the holder was full |
| mute | output | 1 | Current mute state |

## Verification
The table of frames includes all-zero and all-one bytes and alternating patterns in both phases. It also includes single set bits at each end of the byte, which separates a correct LSB-first shift from a reversed one and shows whether a bit is sampled in the middle or at its edge. One entry skips the read, so the old byte has to survive with the overrun flag raised, and the next entry shows that a read clears that condition. The directed cases then apply a short low glitch and a low stop bit, which separate mid-start and mid-stop checks from edge-only detection. They also hold the line idle while muted before and after the first character, which separates an armed wake-up from an unarmed one. Finally, a short and then a full idle gap after a mute write shows whether the idle count restarts on that write.

// File: rtl/urx_mute_pkg.sv
`timescale 1ns/1ps
package urx_mute_pkg;

    // Frame engine states
    typedef enum logic [1:0] {
        FR_HUNT  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } frame_state_t;

endpackage

// File: rtl/urx_line_sync.sv
`timescale 1ns/1ps
module urx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b1;
                else        q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], din};
            end
            assign dout = q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/urx_frame_fsm.sv
`timescale 1ns/1ps
module urx_frame_fsm
    import urx_mute_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 enable,
    output logic                 char_ok,
    output logic [DATA_BITS-1:0] char_byte
);

    localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

    frame_state_t         state_q, state_d;
    logic [CW-1:0]        cnt_q;
    logic [BW-1:0]        bit_q;
    logic [DATA_BITS-1:0] shift_q;
    logic                 mid_start;
    logic                 bit_end;

    assign mid_start = tick && (cnt_q == MID_CNT);
    assign bit_end   = tick && (cnt_q == LAST_CNT);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_HUNT:  if (tick && !line) state_d = FR_START;
            FR_START: if (mid_start)     state_d = line ? FR_HUNT : FR_DATA;
            FR_DATA:  if (bit_end && (bit_q == LAST_BIT)) state_d = FR_STOP;
            FR_STOP:  if (bit_end)       state_d = FR_HUNT;
            default:                     state_d = FR_HUNT;
        endcase
        if (!enable) state_d = FR_HUNT;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_HUNT;
        else        state_q <= state_d;
    end

    // Counters, shifter and character pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            char_ok <= 1'b0;
        end else begin
            char_ok <= 1'b0;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (bit_end) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (state_q == FR_START) begin
                bit_q <= '0;
            end else if (state_q == FR_DATA && bit_end) begin
                shift_q <= {line, shift_q[DATA_BITS-1:1]};
                bit_q   <= bit_q + 1'b1;
            end

            if (enable && state_q == FR_STOP && bit_end && line) begin
                char_ok <= 1'b1;
            end
        end
    end

    assign char_byte = shift_q;

endmodule

// File: rtl/urx_idle_detect.sv
`timescale 1ns/1ps
module urx_idle_detect #(
    parameter int LIMIT = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic enable,
    input  logic restart,
    output logic idle_hit
);

    localparam int IW = $clog2(LIMIT + 1);
    localparam logic [IW-1:0] LAST = IW'(LIMIT - 1);
    localparam logic [IW-1:0] SAT  = IW'(LIMIT);

    logic [IW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            idle_hit <= 1'b0;
        end else begin
            idle_hit <= 1'b0;
            if (!enable || restart) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (!line) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q    <= SAT;
                    idle_hit <= 1'b1;
                end else if (cnt_q != SAT) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/urx_mute_rx.sv
`timescale 1ns/1ps
module urx_mute_rx
    import urx_mute_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int IDLE_BITS   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 rx_en,
    input  logic                 mute_wr,
    input  logic                 mute_wval,
    input  logic                 rd_stb,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 rx_overrun,
    output logic                 mute
);

    localparam int IDLE_TICKS = IDLE_BITS * OVERSAMPLE;

    logic                 line_s;
    logic                 char_ok;
    logic [DATA_BITS-1:0] char_byte;
    logic                 idle_hit;
    logic                 seen_q;
    logic                 deliver;
    logic                 mute_restart;

    urx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    urx_frame_fsm #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .line     (line_s),
        .enable   (rx_en),
        .char_ok  (char_ok),
        .char_byte(char_byte)
    );

    assign mute_restart = mute_wr && mute_wval;

    urx_idle_detect #(.LIMIT(IDLE_TICKS)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .line    (line_s),
        .enable  (rx_en),
        .restart (mute_restart),
        .idle_hit(idle_hit)
    );

    assign deliver = char_ok && !mute;

    // Holding register: no reset value
    always_ff @(posedge clk) begin
        if (deliver && !(rx_full && !rd_stb)) begin
            rx_data <= char_byte;
        end
    end

    // Flags, mute bit and wake-up arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_full    <= 1'b0;
            rx_overrun <= 1'b0;
            mute       <= 1'b0;
            seen_q     <= 1'b0;
        end else begin
            if (deliver) begin
                rx_full <= 1'b1;
            end else if (rd_stb) begin
                rx_full <= 1'b0;
            end

            if (deliver && rx_full && !rd_stb) begin
                rx_overrun <= 1'b1;
            end else if (rd_stb) begin
                rx_overrun <= 1'b0;
            end

            if (char_ok) begin
                seen_q <= 1'b1;
            end

            if (mute_wr) begin
                mute <= mute_wval;
            end else if (idle_hit && seen_q) begin
                mute <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/urx_mute_rx_chk.sv
`timescale 1ns/1ps
module urx_mute_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 mute_wr,
    input logic                 mute_wval,
    input logic                 rd_stb,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_full,
    input logic                 rx_overrun,
    input logic                 mute,
    input logic                 char_ok,
    input logic                 idle_hit,
    input logic                 seen_q
);

    AST_OFF_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !char_ok); // R1

    AST_DELIVER_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (char_ok && !mute) |=> rx_full); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !(char_ok && !mute)) |=> (!rx_full && !rx_overrun)); // R5

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (char_ok && !mute && rx_full && !rd_stb) |=> (rx_overrun && $stable(rx_data))); // R6

    AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mute_wr |=> (mute == $past(mute_wval))); // R7

    AST_MUTED_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && char_ok) |=> $stable(rx_data)); // R8

    AST_MUTED_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && char_ok && !rd_stb) |=> (rx_full == $past(rx_full))); // R8

    AST_WAKE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && !idle_hit && !mute_wr) |=> mute); // R9

    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && idle_hit && seen_q && !mute_wr) |=> !mute); // R9

    AST_UNARMED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && !seen_q && !mute_wr) |=> mute); // R10

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rx_full && !rx_overrun && !mute)); // R11

endmodule

bind urx_mute_rx urx_mute_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .mute_wr   (mute_wr),
    .mute_wval (mute_wval),
    .rd_stb    (rd_stb),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .rx_overrun(rx_overrun),
    .mute      (mute),
    .char_ok   (char_ok),
    .idle_hit  (idle_hit),
    .seen_q    (seen_q)
);

// File: tb/urx_mute_rx_test.sv
`timescale 1ns/1ps
module urx_mute_rx_test;

    localparam int BIT_CLKS = 32;   // 16 ticks, one tick every 2 clocks

    // {read_before, sent byte, expected rx_data, expected overrun}
    localparam logic [17:0] VEC [8] = '{
        {1'b1, 8'h00, 8'h00, 1'b0},
        {1'b1, 8'hFF, 8'hFF, 1'b0},
        {1'b1, 8'hA5, 8'hA5, 1'b0},
        {1'b1, 8'h5A, 8'h5A, 1'b0},
        {1'b0, 8'h3C, 8'h5A, 1'b1},
        {1'b1, 8'h81, 8'h81, 1'b0},
        {1'b1, 8'h01, 8'h01, 1'b0},
        {1'b1, 8'h80, 8'h80, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       mute_wr = 1'b0;
    logic       mute_wval = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       rx_overrun;
    logic       mute;

    int compared = 0;
    int mismatched = 0;

    logic       v_rd;
    logic [7:0] v_byte;
    logic [7:0] v_exp;
    logic       v_ov;

    urx_mute_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .rx_en     (rx_en),
        .mute_wr   (mute_wr),
        .mute_wval (mute_wval),
        .rd_stb    (rd_stb),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .rx_overrun(rx_overrun),
        .mute      (mute)
    );

    initial forever #2.5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        os_tick = ~os_tick;
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rxd = 1'b1;
        rx_en = 1'b0;
        mute_wr = 1'b0;
        rd_stb = 1'b0;
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        wait_clks(1);
        rd_stb = 1'b0;
        wait_clks(1);
    endtask

    task automatic wr_mute(input logic v);
        mute_wr = 1'b1;
        mute_wval = v;
        wait_clks(1);
        mute_wr = 1'b0;
        wait_clks(1);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_hi);
        rxd = 1'b0;
        wait_clks(BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_clks(BIT_CLKS);
        end
        if (stop_hi) begin
            rxd = 1'b1;
            wait_clks(BIT_CLKS);
        end else begin
            rxd = 1'b0;
            wait_clks(24);
            rxd = 1'b1;
            wait_clks(BIT_CLKS);
        end
        rxd = 1'b1;
        wait_clks(BIT_CLKS);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        do_reset();
        chk("R11 full", {15'd0, rx_full}, 16'd0);
        chk("R11 overrun", {15'd0, rx_overrun}, 16'd0);
        chk("R11 mute", {15'd0, mute}, 16'd0);

        rx_en = 1'b1;
        wait_clks(64);

        // Table of frames: R2 data path, R5 read, R6 overrun
        for (int i = 0; i < 8; i++) begin
            {v_rd, v_byte, v_exp, v_ov} = VEC[i];
            if (v_rd) begin
                do_read();
                chk("R5 full after read", {15'd0, rx_full}, 16'd0);
                chk("R5 overrun after read", {15'd0, rx_overrun}, 16'd0);
            end
            send_frame(v_byte, 1'b1);
            chk("R2 data", {8'd0, rx_data}, {8'd0, v_exp});
            chk("R2 full", {15'd0, rx_full}, 16'd1);
            chk("R6 overrun", {15'd0, rx_overrun}, {15'd0, v_ov});
        end
        do_read();

        // R1: disabled receiver ignores the line
        rx_en = 1'b0;
        send_frame(8'h12, 1'b1);
        chk("R1 full", {15'd0, rx_full}, 16'd0);
        chk("R1 data", {8'd0, rx_data}, 16'h0080);
        rx_en = 1'b1;
        wait_clks(64);

        // R3: false start glitch, then a normal frame
        rxd = 1'b0;
        wait_clks(8);
        rxd = 1'b1;
        wait_clks(400);
        chk("R3 no char", {15'd0, rx_full}, 16'd0);
        chk("R3 data kept", {8'd0, rx_data}, 16'h0080);
        send_frame(8'h6E, 1'b1);
        chk("R3 recover data", {8'd0, rx_data}, 16'h006E);
        chk("R3 recover full", {15'd0, rx_full}, 16'd1);
        do_read();

        // R4: low stop bit discards the frame
        send_frame(8'h77, 1'b0);
        wait_clks(400);
        chk("R4 full", {15'd0, rx_full}, 16'd0);
        chk("R4 data", {8'd0, rx_data}, 16'h006E);

        // R7: software writes
        wr_mute(1'b1);
        chk("R7 set", {15'd0, mute}, 16'd1);
        wr_mute(1'b0);
        chk("R7 clear", {15'd0, mute}, 16'd0);

        // R10, R8, R9: mute before any character
        do_reset();
        rx_en = 1'b1;
        wait_clks(8);
        wr_mute(1'b1);
        wait_clks(500);
        chk("R10 unarmed stays muted", {15'd0, mute}, 16'd1);
        send_frame(8'h3C, 1'b1);
        chk("R8 muted no full", {15'd0, rx_full}, 16'd0);
        chk("R8 still muted", {15'd0, mute}, 16'd1);
        wait_clks(400);
        chk("R9 wake after idle", {15'd0, mute}, 16'd0);
        chk("R8 muted char dropped", {15'd0, rx_full}, 16'd0);

        // R9: mute write restarts the idle count
        wait_clks(400);
        wr_mute(1'b1);
        wait_clks(200);
        chk("R9 short idle keeps mute", {15'd0, mute}, 16'd1);
        wait_clks(200);
        chk("R9 full idle wakes", {15'd0, mute}, 16'd0);

        // R8: active again, characters delivered
        send_frame(8'h99, 1'b1);
        chk("R8 active data", {8'd0, rx_data}, 16'h0099);
        chk("R8 active full", {15'd0, rx_full}, 16'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule